// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block is a register-mapped timer bank holding six independent 32-bit down-counters. Each channel owns a control word, a reload (interval) value and a live count that software can read or overwrite at any time. While its start bit is set, a channel steps its count down by one on every tick. A per-channel prescaler, programmable from divide-by-1 to divide-by-8, derives the ticks from the block clock.

When a count steps from one to zero, the channel raises its bit in a shared pending register. A periodic channel then reloads from its interval on the following tick and keeps running. A one-shot channel clears its own start bit and rests at zero. Pending bits are cleared by writing ones. A shared enable register masks them onto a single interrupt line. The clock-source field of the control word is only stored. Software typically loads the live count to place the first event and the interval to set the period after it, then writes the control word.

Top module: `tick_bank`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Registers sit at byte offsets enable 0x00 (bit x for channel x), pending 0x04, and for channel x control 0x10+0x10*x, interval 0x14+0x10*x, live count 0x18+0x10*x. The control word is start bit 0, autoreload bit 1, stored-only clock source bits 3:2, prescaler bits 6:4 and single-shot mode bit 7. Its bits 31:8 read zero. The enable and pending registers are six bits wide.
- R3: While start is set, the live count drops by one per tick. A prescaler field p gives one tick every p+1 clocks, and the first tick lands p+1 clocks after the clock edge that writes start.
- R4: A tick that takes the count from 1 to 0 sets that channel's pending bit, whatever its enable bit holds.
- R5: With autoreload 1 and mode 0 (periodic), a tick at count zero loads the interval value, and start stays set.
- R6: With mode 1 or autoreload 0 (one-shot), hardware clears start when the count reaches zero, and the count stays at zero.
- R7: A write to the live count sets the first expiry independently of the interval, so the first period may differ from later ones.
- R8: While start is clear the live count holds its value, so ticks elapsed from a start at all-ones equal all-ones minus the count.
- R9: Writing 1 to a pending bit clears it. Bits written 0 keep their value.
- R10: `irq` is high exactly when some channel has both its pending and enable bits set.
- R11: Channels are independent: activity on one changes no other channel's registers or pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the prescaler source |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address; bits 1:0 must be zero |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the access, zero when idle |
| irq | output | 1 | Combined masked interrupt |

## Verification
A wrong prescaler count or a wrong decrement shows up as `irq` rising one or more cycles early or late, so the bench times the first rise to the exact clock. A periodic reload from the wrong value, or one taken at the wrong moment, shows within one period in a cycle-by-cycle read of the live count. A start bit that is not cleared, or a counter that keeps moving while stopped, shows as a live count that differs from its earlier read a few cycles later. A pending flag landing on the wrong channel shows at once in the pending register.

// File: rtl/tick_pkg.sv
package tick_pkg;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 8;
    localparam int PRE_W      = 3;
    localparam int CTRL_W     = 8;
    localparam int NUM_CH_DEF = 6;

    // control word, field order fixed by the register layout
    typedef struct packed {
        logic             single;
        logic [PRE_W-1:0] prescale;
        logic [1:0]       src;
        logic             autoreload;
        logic             start;
    } ctrl_t;

    typedef enum logic [2:0] {
        RD_NONE = 3'd0,
        RD_IEN  = 3'd1,
        RD_PEND = 3'd2,
        RD_CTRL = 3'd3,
        RD_INTV = 3'd4,
        RD_CUR  = 3'd5
    } rd_kind_e;

    function automatic ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        return ctrl_t'(w[CTRL_W-1:0]);
    endfunction

    function automatic logic is_periodic(input ctrl_t c);
        return c.autoreload && !c.single;
    endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PRE_W-1:0] div_sel,
    output logic             tick
);
    logic [PRE_W-1:0] pcnt;

    assign tick = run && (pcnt == div_sel);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/tick_decode.sv
module tick_decode
    import tick_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CH_W   = 3
) (
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output rd_kind_e          rd_kind,
    output logic [CH_W-1:0]   ch_idx,
    output logic              wr_ien,
    output logic              wr_pclr,
    output logic [NUM_CH-1:0] wr_ctrl,
    output logic [NUM_CH-1:0] wr_intv,
    output logic [NUM_CH-1:0] wr_cur
);
    logic [3:0] blk;
    logic [1:0] sub;
    logic       aligned;
    logic       ch_hit;
    logic       wr_any;

    assign blk     = bus_addr[7:4];
    assign sub     = bus_addr[3:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign ch_hit  = (blk != 4'd0) && (int'(blk) <= NUM_CH);
    assign ch_idx  = CH_W'(blk - 4'd1);
    assign wr_any  = bus_en && bus_we;

    always_comb begin
        rd_kind = RD_NONE;
        if (aligned) begin
            if (blk == 4'd0) begin
                case (sub)
                    2'd0:    rd_kind = RD_IEN;
                    2'd1:    rd_kind = RD_PEND;
                    default: rd_kind = RD_NONE;
                endcase
            end else if (ch_hit) begin
                case (sub)
                    2'd0:    rd_kind = RD_CTRL;
                    2'd1:    rd_kind = RD_INTV;
                    2'd2:    rd_kind = RD_CUR;
                    default: rd_kind = RD_NONE;
                endcase
            end
        end
    end

    assign wr_ien  = wr_any && (rd_kind == RD_IEN);
    assign wr_pclr = wr_any && (rd_kind == RD_PEND);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_strobe
        logic sel;
        assign sel        = wr_any && (ch_idx == CH_W'(g));
        assign wr_ctrl[g] = sel && (rd_kind == RD_CTRL);
        assign wr_intv[g] = sel && (rd_kind == RD_INTV);
        assign wr_cur[g]  = sel && (rd_kind == RD_CUR);
    end
endmodule

// File: rtl/tick_channel.sv
module tick_channel
    import tick_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic             wr_intv,
    input  logic             wr_cur,
    input  logic [CNT_W-1:0] wdata,
    output ctrl_t            ctrl_q,
    output logic [CNT_W-1:0] intv_q,
    output logic [CNT_W-1:0] cur_q,
    output logic             expire
);
    logic tick;
    logic periodic;
    logic at_zero;
    logic at_one;
    logic stop_now;

    tick_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.start),
        .div_sel (ctrl_q.prescale),
        .tick    (tick)
    );

    assign periodic = is_periodic(ctrl_q);
    assign at_zero  = (cur_q == '0);
    assign at_one   = (cur_q == CNT_W'(1));
    assign expire   = tick && at_one && !wr_cur;
    assign stop_now = tick && !periodic && (at_one || at_zero);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= word_to_ctrl(DATA_W'(wdata));
        end else if (stop_now) begin
            ctrl_q.start <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            intv_q <= '0;
        end else if (wr_intv) begin
            intv_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else if (wr_cur) begin
            cur_q <= wdata;
        end else if (tick) begin
            if (!at_zero) begin
                cur_q <= cur_q - 1'b1;
            end else if (periodic) begin
                cur_q <= intv_q;
            end
        end
    end

    // R3: a running tick from a nonzero count lowers it by exactly one
    assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
        tick && !wr_cur && (cur_q != '0) |=> cur_q == $past(cur_q) - 1'b1);

    // R5: periodic reload takes the interval held before the edge
    assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
        tick && at_zero && periodic && !wr_cur |=> cur_q == $past(intv_q));

    // R6: a one-shot expiry leaves the channel stopped at zero
    assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (rst)
        expire && !periodic && !wr_ctrl |=> !ctrl_q.start && (cur_q == '0));

    // R8: a stopped channel keeps its count unless software writes it
    assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.start && !wr_cur |=> $stable(cur_q));
endmodule

// File: rtl/tick_bank.sv
module tick_bank
    import tick_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    rd_kind_e          rd_kind;
    logic [CH_W-1:0]   ch_idx;
    logic              wr_ien;
    logic              wr_pclr;
    logic [NUM_CH-1:0] wr_ctrl;
    logic [NUM_CH-1:0] wr_intv;
    logic [NUM_CH-1:0] wr_cur;
    logic [NUM_CH-1:0] expire;
    logic [NUM_CH-1:0] ien_q;
    logic [NUM_CH-1:0] pend_q;
    logic [NUM_CH-1:0] clr_mask;

    ctrl_t             ch_ctrl [NUM_CH];
    logic [DATA_W-1:0] ch_intv [NUM_CH];
    logic [DATA_W-1:0] ch_cur  [NUM_CH];

    tick_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .rd_kind  (rd_kind),
        .ch_idx   (ch_idx),
        .wr_ien   (wr_ien),
        .wr_pclr  (wr_pclr),
        .wr_ctrl  (wr_ctrl),
        .wr_intv  (wr_intv),
        .wr_cur   (wr_cur)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tick_channel #(.CNT_W(DATA_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .wr_ctrl (wr_ctrl[g]),
            .wr_intv (wr_intv[g]),
            .wr_cur  (wr_cur[g]),
            .wdata   (bus_wdata),
            .ctrl_q  (ch_ctrl[g]),
            .intv_q  (ch_intv[g]),
            .cur_q   (ch_cur[g]),
            .expire  (expire[g])
        );

        // R4: every expiry is recorded as pending on the following cycle
        assert_expire_pends_R4: assert property (@(posedge clk) disable iff (rst)
            expire[g] |=> pend_q[g]);

        // R9: a one written to a pending bit removes it when no new expiry lands
        assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
            wr_pclr && bus_wdata[g] && !expire[g] |=> !pend_q[g]);
    end

    assign clr_mask = wr_pclr ? bus_wdata[NUM_CH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q  <= '0;
            pend_q <= '0;
        end else begin
            if (wr_ien) begin
                ien_q <= bus_wdata[NUM_CH-1:0];
            end
            pend_q <= (pend_q & ~clr_mask) | expire;
        end
    end

    assign irq = |(pend_q & ien_q);

    always_comb begin
        bus_rdata = '0;
        if (bus_en) begin
            case (rd_kind)
                RD_IEN:  bus_rdata = DATA_W'(ien_q);
                RD_PEND: bus_rdata = DATA_W'(pend_q);
                RD_CTRL: bus_rdata = DATA_W'(ch_ctrl[ch_idx]);
                RD_INTV: bus_rdata = ch_intv[ch_idx];
                RD_CUR:  bus_rdata = ch_cur[ch_idx];
                default: bus_rdata = '0;
            endcase
        end
    end

    // R10: the interrupt line needs at least one enabled channel
    assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ien_q != '0));
endmodule

// File: tb/test_tick_bank.sv
`timescale 1ns/1ps
module test_tick_bank;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_en;
    logic        bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tick_bank i_tick_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the write edge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    // samples at the current negedge, then moves one cycle on
    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    task automatic clean_up();
        bus_write(8'h00, 32'h0);
        bus_write(8'h04, 32'h3F);
    endtask

    task automatic t_reset();
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        expect_reg("R1 enable", 8'h00, 32'h0);
        expect_reg("R1 pending", 8'h04, 32'h0);
        expect_reg("R1 ch0 control", 8'h10, 32'h0);
        expect_reg("R1 ch0 count", 8'h18, 32'h0);
        expect_reg("R1 ch5 interval", 8'h64, 32'h0);
    endtask

    task automatic t_readback();
        bus_write(8'h14, 32'h1234_5678);
        expect_reg("R2 ch0 interval", 8'h14, 32'h1234_5678);
        bus_write(8'h20, 32'hFFFF_FF7C);   // start 0, source 3, prescaler 7
        expect_reg("R2 ch1 control upper bits zero", 8'h20, 32'h0000_007C);
        bus_write(8'h58, 32'h0000_00A5);
        expect_reg("R2 ch4 count", 8'h58, 32'h0000_00A5);
        bus_write(8'h00, 32'hFFFF_FFFF);
        expect_reg("R2 enable width", 8'h00, 32'h0000_003F);
        bus_write(8'h04, 32'hFFFF_FFFF);
        expect_reg("R9 clearing idle pending", 8'h04, 32'h0);
        bus_write(8'h20, 32'h0);
        clean_up();
    endtask

    task automatic t_oneshot_timing();
        bus_write(8'h00, 32'h1);
        bus_write(8'h18, 32'd5);
        bus_write(8'h10, 32'h81);          // start, single
        for (int k = 0; k < 8; k++) begin
            check($sformatf("R3 R4 irq at cycle %0d", k), {31'b0, irq}, (k >= 5) ? 32'h1 : 32'h0);
            @(negedge clk);
        end
        expect_reg("R6 single mode clears start", 8'h10, 32'h80);
        expect_reg("R6 count held at zero", 8'h18, 32'h0);
        bus_write(8'h00, 32'h0);
        check("R10 masked irq", {31'b0, irq}, 32'h0);
        bus_write(8'h04, 32'h1);
        expect_reg("R9 pending cleared", 8'h04, 32'h0);
        clean_up();
    endtask

    task automatic t_prescale();
        bus_write(8'h00, 32'h2);
        bus_write(8'h28, 32'd2);
        bus_write(8'h20, 32'hB1);          // start, prescaler 3, single
        for (int k = 0; k < 11; k++) begin
            check($sformatf("R3 divide-by-4 irq at cycle %0d", k), {31'b0, irq}, (k >= 8) ? 32'h1 : 32'h0);
            @(negedge clk);
        end
        clean_up();
    endtask

    task automatic t_periodic();
        logic [31:0] model;
        logic [31:0] d;
        bus_write(8'h34, 32'd3);
        bus_write(8'h38, 32'd2);           // first expiry differs from interval
        bus_write(8'h30, 32'h03);          // start, autoreload, continuous
        model = 32'd2;
        for (int k = 0; k < 10; k++) begin
            bus_read(8'h38, d);
            check($sformatf("R5 R7 periodic count at cycle %0d", k), d, model);
            model = (model == 0) ? 32'd3 : model - 1;
        end
        expect_reg("R5 start kept", 8'h30, 32'h03);
        expect_reg("R4 periodic pending", 8'h04, 32'h04);
        bus_write(8'h30, 32'h0);
        clean_up();
    endtask

    task automatic t_max_and_freeze();
        logic [31:0] d;
        logic [31:0] first;
        bus_write(8'h48, 32'hFFFF_FFFF);
        bus_write(8'h40, 32'h81);
        for (int k = 0; k < 3; k++) begin
            bus_read(8'h48, d);
            check($sformatf("R3 from all-ones cycle %0d", k), d, 32'hFFFF_FFFF - k);
        end
        bus_write(8'h40, 32'h0);           // the tick on this edge still lands
        bus_read(8'h48, first);
        check("R8 elapsed ticks", 32'hFFFF_FFFF - first, 32'd4);
        repeat (10) @(negedge clk);
        bus_read(8'h48, d);
        check("R8 count frozen", d, first);
        clean_up();
    endtask

    task automatic t_oneshot_variants();
        bus_write(8'h18, 32'd1);
        bus_write(8'h10, 32'h01);          // autoreload 0, continuous
        repeat (3) @(negedge clk);
        expect_reg("R6 no autoreload stops", 8'h10, 32'h0);
        expect_reg("R6 no autoreload count", 8'h18, 32'h0);
        expect_reg("R4 pending without enable", 8'h04, 32'h1);
        bus_write(8'h04, 32'h1);
        bus_write(8'h18, 32'd2);
        bus_write(8'h10, 32'h83);          // autoreload with single mode
        repeat (5) @(negedge clk);
        expect_reg("R6 single overrides autoreload", 8'h10, 32'h82);
        expect_reg("R6 single count", 8'h18, 32'h0);
        clean_up();
    endtask

    task automatic t_independent();
        bus_write(8'h00, 32'h01);
        bus_write(8'h58, 32'd7);
        bus_write(8'h50, 32'h0);
        bus_write(8'h18, 32'd1);
        bus_write(8'h68, 32'd3);
        bus_write(8'h10, 32'h81);
        bus_write(8'h60, 32'h81);
        repeat (6) @(negedge clk);
        expect_reg("R11 R4 both pending", 8'h04, 32'h21);
        expect_reg("R11 idle neighbour count", 8'h58, 32'd7);
        expect_reg("R11 idle neighbour control", 8'h50, 32'h0);
        check("R10 enabled ch0 drives irq", {31'b0, irq}, 32'h1);
        bus_write(8'h04, 32'h20);
        expect_reg("R9 selective clear", 8'h04, 32'h01);
        check("R10 irq kept by ch0", {31'b0, irq}, 32'h1);
        bus_write(8'h04, 32'h01);
        check("R10 irq after clear", {31'b0, irq}, 32'h0);
        bus_write(8'h00, 32'h20);
        check("R10 enable on empty pending", {31'b0, irq}, 32'h0);
        clean_up();
    endtask

    initial begin
        rst = 1'b1; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_readback();
        t_oneshot_timing();
        t_prescale();
        t_periodic();
        t_max_and_freeze();
        t_oneshot_variants();
        t_independent();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule